// File: doc/BRIEF.md
# Paged Memory Map Controller

This block sits beside an 8-bit CPU and decides what the CPU sees in the bottom 16 KB of its address space when an add-on memory card is switched in. It holds a small write-only control register on the I/O bus. The register has a connect bit (bit 7), a sticky RAM-overlay bit (bit 6) and a RAM bank field (bits 5..0, of which only the low `BANK_BITS` drive the RAM address). From this register and a paged-in input driven by separate trigger logic, a combinational decoder drives the chip selects and write enables. It selects the add-on ROM, the add-on RAM or the host ROM, and it forms the RAM bank address.

The lower window is 0000h-1FFFh and the upper window is 2000h-3FFFh. The add-on is active when the connect bit is set or when `paged_in` is high. While it is active, the upper window always shows the selected RAM bank. The lower window shows the add-on ROM unless the overlay bit is set and the connect bit is clear. In that case the last RAM bank stands in for the ROM and is write-protected in both windows. The connect bit restores the ROM and lifts that protection. ROM writes also need the protect jumper to be removed. A soft reset clears the connect bit and the bank but keeps the overlay bit. Only power-on clears the overlay bit.

Top module: `paged_mem_ctrl`

## Requirements
- R1: An `io_wr` pulse with `io_addr` equal to `REG_ADDR` (default E3h) loads the register at the clock edge: bit 7 into connect and bits 5..0 into the bank. A write to any other I/O address changes nothing.
- R2: While `por_n` is low, connect, overlay and bank are all zero.
- R3: A clock edge with `rst_n` low clears connect and bank and leaves the overlay bit unchanged. A soft reset takes priority over a register write in the same cycle.
- R4: The overlay bit (bit 6) is only ever set by a register write. Writing 0 to bit 6 does not clear it.
- R5: When connect is clear and `paged_in` is low, no add-on select is active, and `host_rom_sel` is high for memory accesses in the lower window.
- R6: When the add-on is active, an access in the upper window selects RAM, with `ram_addr` = {bank[BANK_BITS-1:0], cpu_addr[12:0]}.
- R7: Setting connect makes the add-on active at once without `paged_in`, and maps the ROM in the lower window even while the overlay bit is set.
- R8: With the add-on active, the overlay bit set and connect clear, a lower-window access selects RAM bank `2**BANK_BITS-1` with `ram_we` low.
- R9: With the overlay bit set and connect clear, writes to the last bank through the upper window are blocked, while other banks stay writable.
- R10: With connect set, RAM writes in the upper window are enabled for every bank, the last one included.
- R11: `rom_we` is high only for a write in the lower window while connect is set and `wp_jumper` is low (0 = jumper removed).
- R12: At most one of `host_rom_sel`, `rom_sel` and `ram_sel` is high, and none is high while `cpu_mreq` is low or the address is 4000h or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous, clears all register bits |
| rst_n | input | 1 | Soft reset, active low, synchronous, keeps the overlay bit |
| io_wr | input | 1 | I/O write strobe, one cycle |
| io_addr | input | 8 | Low byte of the I/O address |
| io_wdata | input | 8 | I/O write data |
| paged_in | input | 1 | High while the automatic paging logic has the add-on switched in |
| cpu_mreq | input | 1 | Memory request qualifier |
| cpu_wr | input | 1 | Memory write |
| cpu_addr | input | 16 | CPU address |
| wp_jumper | input | 1 | 1 = write-protect jumper fitted |
| host_rom_sel | output | 1 | Host ROM select |
| rom_sel | output | 1 | Add-on ROM select |
| ram_sel | output | 1 | Add-on RAM select |
| rom_we | output | 1 | Add-on ROM write enable |
| ram_we | output | 1 | Add-on RAM write enable |
| ram_addr | output | BANK_BITS+13 | Add-on RAM address |

## Verification
The bench uses the default `BANK_BITS` of 2 and the default register address E3h. With two bank bits, the last bank (3) is reachable both as the overlay bank and as an ordinary upper-window bank. This lets the protection rule be checked against bank 3 and against a neighbouring bank. The 15-bit RAM address shows the bank sitting above the 13 window bits. The vector table runs first without the overlay bit and then with it. Because of this ordering, the sticky behaviour, a soft reset that keeps the overlay bit, and a later power-on that clears it can all be seen at the select and enable outputs.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
    localparam int unsigned FIELD_W    = 6;
    localparam int unsigned CONN_BIT   = 7;
    localparam int unsigned OVL_BIT    = 6;
    localparam int unsigned WIN_BITS   = 13;

    typedef enum logic [1:0] {
        WIN_LOW  = 2'd0,
        WIN_HIGH = 2'd1,
        WIN_NONE = 2'd2
    } win_e;
endpackage

// File: rtl/pmm_ctrl_reg.sv
module pmm_ctrl_reg #(
    parameter int unsigned BANK_BITS = 2,
    parameter logic [7:0]  REG_ADDR  = 8'hE3
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 rst_n,
    input  logic                 io_wr,
    input  logic [7:0]           io_addr,
    input  logic [7:0]           io_wdata,
    output logic                 conn_q,
    output logic                 ovl_q,
    output logic [BANK_BITS-1:0] bank_q
);
    import pmm_pkg::*;

    typedef struct packed {
        logic                 conn;
        logic                 ovl;
        logic [BANK_BITS-1:0] bank;
    } state_t;

    state_t st_d, st_q;
    logic   hit;

    assign hit = io_wr && (io_addr == REG_ADDR);

    generate
        if (BANK_BITS < FIELD_W) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^io_wdata[FIELD_W-1:BANK_BITS];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.conn = 1'b0;
            st_d.bank = '0;
        end else if (hit) begin
            st_d.conn = io_wdata[CONN_BIT];
            st_d.ovl  = st_q.ovl | io_wdata[OVL_BIT];
            st_d.bank = io_wdata[BANK_BITS-1:0];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign conn_q = st_q.conn;
    assign ovl_q  = st_q.ovl;
    assign bank_q = st_q.bank;

    assert_load_R1: assert property (@(posedge clk) disable iff (!por_n)
        (hit && rst_n) |=> (conn_q == $past(io_wdata[CONN_BIT]) &&
                            bank_q == $past(io_wdata[BANK_BITS-1:0])));
    assert_soft_reset_R3: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> (!conn_q && bank_q == '0 && ovl_q == $past(ovl_q)));
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!por_n)
        ovl_q |=> ovl_q);
    assert_hold_R1: assert property (@(posedge clk) disable iff (!por_n)
        (!hit && rst_n) |=> $stable({conn_q, ovl_q, bank_q}));
endmodule

// File: rtl/pmm_window.sv
module pmm_window (
    input  logic [15:0]       cpu_addr,
    output pmm_pkg::win_e     win
);
    import pmm_pkg::*;

    always_comb begin
        unique case (cpu_addr[15:13])
            3'd0:    win = WIN_LOW;
            3'd1:    win = WIN_HIGH;
            default: win = WIN_NONE;
        endcase
    end
endmodule

// File: rtl/pmm_route.sv
module pmm_route #(
    parameter int unsigned BANK_BITS = 2
) (
    input  pmm_pkg::win_e              win,
    input  logic                       conn,
    input  logic                       ovl,
    input  logic [BANK_BITS-1:0]       bank,
    input  logic                       paged_in,
    input  logic                       cpu_mreq,
    input  logic                       cpu_wr,
    input  logic [12:0]                low_addr,
    input  logic                       wp_jumper,
    output logic                       host_rom_sel,
    output logic                       rom_sel,
    output logic                       ram_sel,
    output logic                       rom_we,
    output logic                       ram_we,
    output logic [BANK_BITS+12:0]      ram_addr
);
    import pmm_pkg::*;

    localparam logic [BANK_BITS-1:0] LAST_BANK = '1;

    logic                 active;
    logic                 overlay_on;
    logic [BANK_BITS-1:0] bank_sel;

    assign active     = conn | paged_in;
    assign overlay_on = ovl & ~conn;

    always_comb begin
        host_rom_sel = 1'b0;
        rom_sel      = 1'b0;
        ram_sel      = 1'b0;
        rom_we       = 1'b0;
        ram_we       = 1'b0;
        bank_sel     = bank;
        if (cpu_mreq) begin
            unique case (win)
                WIN_LOW: begin
                    if (!active) begin
                        host_rom_sel = 1'b1;
                    end else if (overlay_on) begin
                        ram_sel  = 1'b1;
                        bank_sel = LAST_BANK;
                    end else begin
                        rom_sel = 1'b1;
                        rom_we  = cpu_wr & conn & ~wp_jumper;
                    end
                end
                WIN_HIGH: begin
                    if (active) begin
                        ram_sel = 1'b1;
                        ram_we  = cpu_wr & ~(overlay_on && bank == LAST_BANK);
                    end
                end
                default: ;
            endcase
        end
    end

    assign ram_addr = {bank_sel, low_addr};
endmodule

// File: rtl/paged_mem_ctrl.sv
module paged_mem_ctrl #(
    parameter int unsigned BANK_BITS = 2,
    parameter logic [7:0]  REG_ADDR  = 8'hE3,
    localparam int unsigned RAM_AW   = BANK_BITS + pmm_pkg::WIN_BITS
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [7:0]        io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              paged_in,
    input  logic              cpu_mreq,
    input  logic              cpu_wr,
    input  logic [15:0]       cpu_addr,
    input  logic              wp_jumper,
    output logic              host_rom_sel,
    output logic              rom_sel,
    output logic              ram_sel,
    output logic              rom_we,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr
);
    import pmm_pkg::*;

    logic                 conn_q;
    logic                 ovl_q;
    logic [BANK_BITS-1:0] bank_q;
    win_e                 win;

    pmm_ctrl_reg #(.BANK_BITS(BANK_BITS), .REG_ADDR(REG_ADDR)) u_reg (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .io_wr(io_wr),
        .io_addr(io_addr), .io_wdata(io_wdata),
        .conn_q(conn_q), .ovl_q(ovl_q), .bank_q(bank_q)
    );

    pmm_window u_win (.cpu_addr(cpu_addr), .win(win));

    pmm_route #(.BANK_BITS(BANK_BITS)) u_route (
        .win(win), .conn(conn_q), .ovl(ovl_q), .bank(bank_q),
        .paged_in(paged_in), .cpu_mreq(cpu_mreq), .cpu_wr(cpu_wr),
        .low_addr(cpu_addr[WIN_BITS-1:0]), .wp_jumper(wp_jumper),
        .host_rom_sel(host_rom_sel), .rom_sel(rom_sel), .ram_sel(ram_sel),
        .rom_we(rom_we), .ram_we(ram_we), .ram_addr(ram_addr)
    );

    assert_one_select_R12: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({host_rom_sel, rom_sel, ram_sel}));
    assert_idle_R5: assert property (@(posedge clk) disable iff (!por_n)
        (!conn_q && !paged_in) |-> (!rom_sel && !ram_sel));
    assert_rom_we_R11: assert property (@(posedge clk) disable iff (!por_n)
        rom_we |-> (conn_q && !wp_jumper && cpu_wr && rom_sel));
    assert_last_bank_prot_R9: assert property (@(posedge clk) disable iff (!por_n)
        (ovl_q && !conn_q && ram_sel && ram_addr[RAM_AW-1 -: BANK_BITS] == '1) |-> !ram_we);
    assert_conn_writable_R10: assert property (@(posedge clk) disable iff (!por_n)
        (conn_q && ram_sel && cpu_wr) |-> ram_we);
endmodule

// File: tb/paged_mem_ctrl_tb_top.sv
module paged_mem_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 17;

    typedef struct packed {
        logic [7:0]  ctrl;
        logic        paged;
        logic        wr;
        logic        wp;
        logic [15:0] a;
        logic [4:0]  exp;   // {host, rom, ram, rom_we, ram_we}
        logic [14:0] ea;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{8'h00, 1'b0, 1'b0, 1'b1, 16'h0100, 5'b10000, 15'h0000, 8'd5},  // R5
        '{8'h00, 1'b0, 1'b0, 1'b1, 16'h2345, 5'b00000, 15'h0000, 8'd5},  // R5
        '{8'h02, 1'b1, 1'b1, 1'b1, 16'h2345, 5'b00101, 15'h4345, 8'd6},  // R6
        '{8'h01, 1'b1, 1'b0, 1'b1, 16'h0010, 5'b01000, 15'h0000, 8'd6},  // R6
        '{8'h01, 1'b1, 1'b1, 1'b1, 16'h0010, 5'b01000, 15'h0000, 8'd11}, // R11
        '{8'h81, 1'b0, 1'b1, 1'b0, 16'h1FFF, 5'b01010, 15'h0000, 8'd7},  // R7
        '{8'h83, 1'b0, 1'b1, 1'b1, 16'h3FFF, 5'b00101, 15'h7FFF, 8'd10}, // R10
        '{8'h03, 1'b1, 1'b1, 1'b0, 16'h0000, 5'b01000, 15'h0000, 8'd11}, // R11
        '{8'h03, 1'b1, 1'b1, 1'b0, 16'h3000, 5'b00101, 15'h7000, 8'd9},  // R9
        '{8'h80, 1'b1, 1'b0, 1'b1, 16'h4000, 5'b00000, 15'h0000, 8'd12}, // R12
        '{8'h41, 1'b1, 1'b1, 1'b0, 16'h0123, 5'b00100, 15'h6123, 8'd8},  // R8
        '{8'h01, 1'b1, 1'b1, 1'b0, 16'h2123, 5'b00101, 15'h2123, 8'd4},  // R4
        '{8'h03, 1'b1, 1'b1, 1'b0, 16'h2123, 5'b00100, 15'h6123, 8'd9},  // R9
        '{8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 5'b10000, 15'h0000, 8'd5},  // R5
        '{8'hC3, 1'b0, 1'b1, 1'b0, 16'h0800, 5'b01010, 15'h0000, 8'd7},  // R7
        '{8'h83, 1'b0, 1'b1, 1'b1, 16'h2800, 5'b00101, 15'h6800, 8'd10}, // R10
        '{8'h80, 1'b1, 1'b1, 1'b1, 16'h0800, 5'b01000, 15'h0000, 8'd11}  // R11
    };

    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b1;
    logic        io_wr = 1'b0;
    logic [7:0]  io_addr = '0, io_wdata = '0;
    logic        paged_in = 1'b0, cpu_mreq = 1'b1, cpu_wr = 1'b0, wp_jumper = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        host_rom_sel, rom_sel, ram_sel, rom_we, ram_we;
    logic [14:0] ram_addr;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    paged_mem_ctrl dut_i (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .io_wr(io_wr),
        .io_addr(io_addr), .io_wdata(io_wdata), .paged_in(paged_in),
        .cpu_mreq(cpu_mreq), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .wp_jumper(wp_jumper), .host_rom_sel(host_rom_sel), .rom_sel(rom_sel),
        .ram_sel(ram_sel), .rom_we(rom_we), .ram_we(ram_we), .ram_addr(ram_addr)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic access(input logic pg, input logic w, input logic wp, input logic [15:0] a);
        paged_in = pg; cpu_wr = w; wp_jumper = wp; cpu_addr = a;
        #1;
    endtask

    function automatic logic [4:0] outs();
        return {host_rom_sel, rom_sel, ram_sel, rom_we, ram_we};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R2: power-on state
        @(negedge clk); access(1'b0, 1'b0, 1'b1, 16'h0000);
        chk("R2 host selected in reset", 32'(outs()), 32'(5'b10000));
        por_n = 1'b1;
        @(negedge clk); access(1'b1, 1'b0, 1'b1, 16'h0000);
        chk("R2 rom in lower, overlay clear", 32'(outs()), 32'(5'b01000));
        access(1'b1, 1'b0, 1'b1, 16'h2ABC);
        chk("R2 bank zero address", 32'(ram_addr), 32'(15'h0ABC));

        // R1: other address ignored
        reg_write(8'hE7, 8'hC3);
        access(1'b0, 1'b0, 1'b1, 16'h0000);
        chk("R1 other address ignored", 32'(outs()), 32'(5'b10000));
        access(1'b1, 1'b0, 1'b1, 16'h0000);
        chk("R1 overlay not set by other address", 32'(outs()), 32'(5'b01000));

        // table walk
        for (int i = 0; i < NV; i++) begin
            reg_write(8'hE3, VECS[i].ctrl);
            access(VECS[i].paged, VECS[i].wr, VECS[i].wp, VECS[i].a);
            chk($sformatf("R%0d vector %0d selects", VECS[i].req, i), 32'(outs()), 32'(VECS[i].exp));
            if (VECS[i].exp[2])
                chk($sformatf("R%0d vector %0d address", VECS[i].req, i), 32'(ram_addr), 32'(VECS[i].ea));
        end

        // R3: soft reset keeps overlay, clears connect and bank
        reg_write(8'hE3, 8'h82);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        access(1'b0, 1'b0, 1'b1, 16'h0000);
        chk("R3 connect cleared", 32'(outs()), 32'(5'b10000));
        access(1'b1, 1'b1, 1'b0, 16'h0456);
        chk("R3 overlay kept", 32'(outs()), 32'(5'b00100));
        chk("R3 overlay bank", 32'(ram_addr), 32'(15'h6456));
        access(1'b1, 1'b1, 1'b0, 16'h2456);
        chk("R3 bank cleared", 32'(ram_addr), 32'(15'h0456));

        // R3: soft reset beats a same-cycle write
        @(negedge clk);
        rst_n = 1'b0; io_addr = 8'hE3; io_wdata = 8'h82; io_wr = 1'b1;
        @(negedge clk); rst_n = 1'b1; io_wr = 1'b0;
        access(1'b0, 1'b0, 1'b1, 16'h0000);
        chk("R3 reset wins over write", 32'(outs()), 32'(5'b10000));

        // R12: no request, no select
        reg_write(8'hE3, 8'h81);
        cpu_mreq = 1'b0;
        access(1'b1, 1'b1, 1'b0, 16'h0000);
        chk("R12 mreq low lower", 32'(outs()), 32'(5'b00000));
        access(1'b1, 1'b1, 1'b0, 16'h2000);
        chk("R12 mreq low upper", 32'(outs()), 32'(5'b00000));
        cpu_mreq = 1'b1;

        // R2: power-on clears overlay
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        access(1'b1, 1'b0, 1'b1, 16'h0000);
        chk("R2 overlay cleared by power-on", 32'(outs()), 32'(5'b01000));
        access(1'b1, 1'b1, 1'b1, 16'h3000);
        chk("R9 bank writable without overlay", 32'(outs()), 32'(5'b00101));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule